// File: doc/BRIEF.md
# Threshold-Maximizing Sampling Phase Search

This block steers the phase offset of the auxiliary (error) sampling clock in a serial receiver. When it is told that clock recovery and the sign-sign LMS adapter have both settled, it starts a hill climb. The climb drives the offset toward the point where the adapted slicer threshold is highest. A higher threshold means that less of the channel's intersymbol interference is wrongly credited to the feedback taps. The control input is the magnitude of that threshold, not an error count.

Every step the block reads the current threshold code and compares it with the code it stored at the previous step. If the threshold went down, it reverses its search direction; otherwise it keeps the direction it had. It then moves a wide saturating accumulator by a programmable step size in that direction. It moves the accumulator even when the threshold did not change, so the search never stalls. The most significant bits of the accumulator are the phase offset handed to the clock-recovery logic. The step size sets the loop bandwidth.

Steps are taken on every (div_count+1)-th threshold update. After run_steps steps the offset freezes and `done` is raised. Before a run and after `enable` is withdrawn, the offset output is the static offset input. The threshold input is a valid-qualified stream with no ready: the block takes an update in any cycle and never applies back-pressure, and updates outside a run are dropped. All clocks involved are related, so no synchronizer is used.

Top module: `phase_hunt_ctrl`

## Requirements
- R1: While idle (after reset, or after `enable` is low), `ka_out` equals `static_ka` and both `busy` and `done` are low.
- R2: In idle with `enable` high, the next clock edge loads the accumulator with `static_ka` in its top 7 bits and zeros below it. The same edge sets the direction to increment (`dir_up`=1), stores the current `thr_value` as the previous code and clears the step counters. `busy` is high from the following cycle, or `done` is high if `run_steps` is 0.
- R3: While busy, a step is taken on the (div_count+1)-th `thr_valid` pulse counted since the start or since the previous step. Other pulses and cycles without `thr_valid` leave `ka_out` and `dir_up` unchanged.
- R4: At a step, if `thr_value` is below the stored previous code (unsigned compare), `dir_up` inverts. Otherwise it keeps its value. The stored code then becomes `thr_value`.
- R5: Every step adds `step_size` to the accumulator (`dir_up`=1) or subtracts it (`dir_up`=0), using the direction just decided, even when the threshold is unchanged.
- R6: The 24-bit accumulator saturates at 2^24-1 going up and at 0 going down, and never wraps.
- R7: While busy or done, `ka_out` equals accumulator bits [23:17], one cycle after the step edge.
- R8: When the run_steps-th step is taken, `busy` falls and `done` rises on the next cycle. While `enable` stays high, `ka_out` and `dir_up` then stay frozen and `thr_valid` pulses have no effect. `busy` and `done` are never high together.
- R9: Lowering `enable` during a run or while done returns the block to idle at the next edge, so `ka_out` shows `static_ka` from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | High once clock recovery and LMS have converged; low aborts or releases |
| static_ka | input | 7 | Fixed phase offset used in idle and as the starting point |
| step_size | input | 20 | Accumulator increment per step (loop bandwidth) |
| div_count | input | 8 | Threshold updates per step, minus one |
| run_steps | input | 16 | Number of steps before freezing |
| thr_valid | input | 1 | Threshold update strobe from the LMS adapter |
| thr_value | input | 7 | Adapted slicer threshold code, unsigned |
| ka_out | output | 7 | Phase offset to clock recovery |
| dir_up | output | 1 | Current search direction, 1 = increasing |
| busy | output | 1 | Search running |
| done | output | 1 | Search finished, offset frozen |

## Verification
A wrong direction decision shows on `dir_up` in the cycle after the offending step. It shows on `ka_out` only once the accumulator has moved far enough to change its upper bits, so the direction flag is compared on every cycle rather than inferred from the offset. A divider or step-counter fault shifts the step in which `ka_out` moves, or the cycle in which `done` rises, by at least one threshold update. A saturation fault shows as a jump of `ka_out` from 127 to a small value (or from 0 to a large one) after one more step at the limit.

// File: rtl/phase_hunt_pkg.sv
package phase_hunt_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_HOLD = 2'd2
  } ph_state_e;
endpackage

// File: rtl/ph_step_timer.sv
// Divides threshold updates into search steps and counts steps toward the end of the run.
module ph_step_timer #(
  parameter int DIV_W = 8,
  parameter int RUN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             active,
  input  logic             thr_valid,
  input  logic [DIV_W-1:0] div_count,
  input  logic [RUN_W-1:0] run_steps,
  output logic             step_fire,
  output logic             last_step
);
  logic [DIV_W-1:0] div_q;
  logic [RUN_W-1:0] cnt_q;
  logic [RUN_W:0]   cnt_nxt;

  assign cnt_nxt   = {1'b0, cnt_q} + {{RUN_W{1'b0}}, 1'b1};
  assign step_fire = active && thr_valid && (div_q == div_count);
  assign last_step = step_fire && (cnt_nxt == {1'b0, run_steps});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else if (clear) begin
      div_q <= '0;
      cnt_q <= '0;
    end else if (active && thr_valid) begin
      if (div_q == div_count) begin
        div_q <= '0;
        cnt_q <= cnt_nxt[RUN_W-1:0];
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ph_dir_tracker.sv
// Keeps the previous threshold and decides the search direction for each step.
module ph_dir_tracker #(
  parameter int TH_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            step_fire,
  input  logic [TH_W-1:0] thr_value,
  output logic            dir_next,
  output logic            dir_q,
  output logic [TH_W-1:0] prev_q
);
  assign dir_next = (thr_value < prev_q) ? ~dir_q : dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= 1'b1;
      prev_q <= '0;
    end else if (load) begin
      dir_q  <= 1'b1;
      prev_q <= thr_value;
    end else if (step_fire) begin
      dir_q  <= dir_next;
      prev_q <= thr_value;
    end
  end
endmodule

// File: rtl/ph_sat_accum.sv
// Saturating up/down accumulator whose upper bits form the phase offset.
module ph_sat_accum #(
  parameter int ACC_W  = 24,
  parameter int STEP_W = 20,
  parameter int KA_W   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [KA_W-1:0]   load_ka,
  input  logic              step_fire,
  input  logic              go_up,
  input  logic [STEP_W-1:0] step_size,
  output logic [KA_W-1:0]   ka
);
  localparam int EXT_W = ACC_W - STEP_W + 1;
  localparam int LOW_W = ACC_W - KA_W;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_nxt;
  logic [ACC_W:0]   step_ext;
  logic [ACC_W:0]   sum;
  logic [ACC_W:0]   diff;

  assign step_ext = {{EXT_W{1'b0}}, step_size};
  assign sum      = {1'b0, acc_q} + step_ext;
  assign diff     = {1'b0, acc_q} - step_ext;

  always_comb begin
    if (go_up) acc_nxt = sum[ACC_W]  ? {ACC_W{1'b1}} : sum[ACC_W-1:0];
    else       acc_nxt = diff[ACC_W] ? {ACC_W{1'b0}} : diff[ACC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         acc_q <= '0;
    else if (load)      acc_q <= {load_ka, {LOW_W{1'b0}}};
    else if (step_fire) acc_q <= acc_nxt;
  end

  assign ka = acc_q[ACC_W-1 -: KA_W];
endmodule

// File: rtl/phase_hunt_ctrl.sv
module phase_hunt_ctrl #(
  parameter int TH_W   = 7,
  parameter int KA_W   = 7,
  parameter int ACC_W  = 24,
  parameter int STEP_W = 20,
  parameter int DIV_W  = 8,
  parameter int RUN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [KA_W-1:0]   static_ka,
  input  logic [STEP_W-1:0] step_size,
  input  logic [DIV_W-1:0]  div_count,
  input  logic [RUN_W-1:0]  run_steps,
  input  logic              thr_valid,
  input  logic [TH_W-1:0]   thr_value,
  output logic [KA_W-1:0]   ka_out,
  output logic              dir_up,
  output logic              busy,
  output logic              done
);
  import phase_hunt_pkg::*;

  ph_state_e       state_q, state_d;
  logic            start;
  logic            active;
  logic            step_fire;
  logic            last_step;
  logic            dir_next;
  logic [TH_W-1:0] prev_thr;
  logic [KA_W-1:0] acc_ka;

  assign start  = (state_q == PH_IDLE) && enable;
  assign active = (state_q == PH_RUN) && enable;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PH_IDLE: if (enable) state_d = (run_steps == '0) ? PH_HOLD : PH_RUN;
      PH_RUN: begin
        if (!enable)        state_d = PH_IDLE;
        else if (last_step) state_d = PH_HOLD;
      end
      PH_HOLD: if (!enable) state_d = PH_IDLE;
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PH_IDLE;
    else        state_q <= state_d;
  end

  ph_step_timer #(.DIV_W(DIV_W), .RUN_W(RUN_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (start),
    .active    (active),
    .thr_valid (thr_valid),
    .div_count (div_count),
    .run_steps (run_steps),
    .step_fire (step_fire),
    .last_step (last_step)
  );

  ph_dir_tracker #(.TH_W(TH_W)) u_dir (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start),
    .step_fire (step_fire),
    .thr_value (thr_value),
    .dir_next  (dir_next),
    .dir_q     (dir_up),
    .prev_q    (prev_thr)
  );

  ph_sat_accum #(.ACC_W(ACC_W), .STEP_W(STEP_W), .KA_W(KA_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start),
    .load_ka   (static_ka),
    .step_fire (step_fire),
    .go_up     (dir_next),
    .step_size (step_size),
    .ka        (acc_ka)
  );

  assign ka_out = (state_q == PH_IDLE) ? static_ka : acc_ka;
  assign busy   = (state_q == PH_RUN);
  assign done   = (state_q == PH_HOLD);
endmodule

// File: rtl/phase_hunt_chk.sv
module phase_hunt_chk #(
  parameter int TH_W = 7,
  parameter int KA_W = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            enable,
  input logic            thr_valid,
  input logic [TH_W-1:0] thr_value,
  input logic [KA_W-1:0] ka_out,
  input logic            dir_up,
  input logic            busy,
  input logic            done,
  input logic            step_fire,
  input logic [TH_W-1:0] prev_thr
);
  a_r2_start_up: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> dir_up);

  a_r3_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && enable && !thr_valid) |=> ($stable(ka_out) && $stable(dir_up)));

  a_r4_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && (thr_value < prev_thr)) |=> (dir_up != $past(dir_up)));

  a_r4_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && (thr_value >= prev_thr)) |=> $stable(dir_up));

  a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (done && enable) |=> ($stable(ka_out) && $stable(dir_up)));

  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
endmodule

bind phase_hunt_ctrl phase_hunt_chk #(.TH_W(TH_W), .KA_W(KA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .thr_valid (thr_valid),
  .thr_value (thr_value),
  .ka_out    (ka_out),
  .dir_up    (dir_up),
  .busy      (busy),
  .done      (done),
  .step_fire (step_fire),
  .prev_thr  (prev_thr)
);

// File: tb/test_phase_hunt_ctrl.sv
`timescale 1ns/1ps
module test_phase_hunt_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [6:0]  static_ka = '0;
  logic [19:0] step_size = '0;
  logic [7:0]  div_count = '0;
  logic [15:0] run_steps = '0;
  logic        thr_valid = 1'b0;
  logic [6:0]  thr_value = '0;
  logic [6:0]  ka_out;
  logic        dir_up, busy, done;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  int     m_state = 0;
  longint m_acc = 0;
  int     m_dir = 1;
  int     m_prev = 0;
  int     m_div = 0;
  int     m_cnt = 0;
  localparam longint ACC_MAX = 64'd16777215;

  always #2.5 clk = ~clk;

  phase_hunt_ctrl i_phase_hunt_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .static_ka(static_ka),
    .step_size(step_size), .div_count(div_count), .run_steps(run_steps),
    .thr_valid(thr_valid), .thr_value(thr_value), .ka_out(ka_out),
    .dir_up(dir_up), .busy(busy), .done(done)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Expected behaviour from the requirements, advanced once per clock edge.
  task automatic model_edge();
    case (m_state)
      0: if (enable) begin
        m_acc = longint'(static_ka) << 17;             // R2
        m_dir = 1; m_prev = thr_value; m_div = 0; m_cnt = 0;
        m_state = (run_steps == 0) ? 2 : 1;
      end
      1: if (!enable) m_state = 0;                      // R9
      else if (thr_valid) begin
        if (m_div == div_count) begin                   // R3
          m_div = 0;
          if (int'(thr_value) < m_prev) m_dir = 1 - m_dir;  // R4
          m_prev = thr_value;
          if (m_dir == 1) m_acc = (m_acc + step_size > ACC_MAX) ? ACC_MAX : m_acc + step_size; // R5 R6
          else            m_acc = (m_acc < step_size) ? 0 : m_acc - step_size;
          m_cnt++;
          if (m_cnt == run_steps) m_state = 2;          // R8
        end else m_div++;
      end
      default: if (!enable) m_state = 0;
    endcase
  endtask

  task automatic compare();
    if (m_state == 0) begin
      chk("R1", "idle ka_out", ka_out, static_ka);
      chk("R1", "idle busy", busy, 0);
      chk("R1", "idle done", done, 0);
    end else begin
      chk(m_state == 1 ? "R7" : "R8", "ka_out", ka_out, m_acc >> 17);
      chk("R4", "dir_up", dir_up, m_dir);
      chk("R2", "busy", busy, m_state == 1);
      chk("R8", "done", done, m_state == 2);
    end
  endtask

  task automatic cyc(input bit v, input int t);
    thr_valid = v;
    thr_value = t[6:0];
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  function automatic int pat(input int kind, input int i);
    case (kind)
      0: return (10 + i * 3) % 128;
      1: return (120 - i * 3) & 127;
      2: return 70;
      3: return (i % 2) ? 80 : 60;
      4: return (i * 37 + 11 * i * i) % 128;
      5: return 100 - ((i > 12) ? (i - 12) : (12 - i)) * 4;
      default: return (i == 0) ? 100 : 50;
    endcase
  endfunction

  task automatic run_cfg(input int ka0, input int stp, input int dv, input int ns,
                         input int kind, input string tag, input int exp_ka);
    static_ka = ka0[6:0]; step_size = stp[19:0]; div_count = dv[7:0]; run_steps = ns[15:0];
    enable = 1'b1;
    cyc(1, pat(kind, 0));
    if (ns == 0) chk("R8", "done at once", done, 1);
    else begin
      chk("R2", "busy after start", busy, 1);
      chk("R2", "dir after start", dir_up, 1);
    end
    for (int i = 1; i < (ns + 2) * (dv + 1) * 3 / 2 + 4; i++)
      cyc((i % 3) != 0, pat(kind, i));
    chk(tag, "run finished", done, 1);
    if (exp_ka >= 0) chk(tag, "final ka_out", ka_out, exp_ka);
    for (int i = 0; i < 4; i++) cyc(1, (i * 50) % 128);   // R8 pulses ignored when done
    enable = 1'b0;
    cyc(0, 0);
    chk("R9", "ka_out after release", ka_out, ka0);
    cyc(1, 5);
  endtask

  initial begin
    #750000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare();
    cyc(1, 20);
    // Directed boundary runs with arithmetically known results.
    run_cfg(40, 20'h20000, 0, 6, 2, "R5", 46);
    run_cfg(10, 20'h20000, 2, 4, 2, "R3", 14);
    run_cfg(127, 20'hFFFFF, 0, 5, 2, "R6", 127);
    run_cfg(0, 20'hFFFFF, 0, 5, 6, "R6", 0);
    run_cfg(33, 20'h20000, 0, 0, 2, "R8", 33);
    // Sweep of patterns, dividers and step sizes.
    for (int k = 0; k < 6; k++)
      for (int d = 0; d < 3; d += 2)
        for (int s = 0; s < 2; s++)
          run_cfg(20 + k * 15, s ? 20'h3000 : 20'h20000, d, 24, k, "R7", -1);
    // Abort in the middle of a run.
    static_ka = 7'd50; step_size = 20'h20000; div_count = 8'd0; run_steps = 16'd100;
    enable = 1'b1;
    cyc(1, 30);
    for (int i = 0; i < 10; i++) cyc(1, 30 + i);
    enable = 1'b0;
    cyc(1, 60);
    chk("R9", "abort ka_out", ka_out, 50);
    chk("R9", "abort busy", busy, 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule